// File: doc/BRIEF.md
# PCI host bridge control register block

This block is the processor-facing control window of a PCI host bridge. It sits on a simple 32-bit register bus that has a request valid, a ready response and byte enables. The window holds a 256-byte copy of the bridge's own configuration header and three control registers: a configuration target address, a memory base and an I/O base.

A data port turns processor accesses into configuration cycles on an external request/acknowledge interface, with the target address taken from the address register. While such a cycle is outstanding, the register bus is held waiting. The I/O base supplies the upper address bits for a 256 KiB I/O window translator, which runs continuously beside the register bus.

Interrupt levels from a fixed set of device slots are steered onto four output lines. Each slot's line is chosen by the device-number field of its device/function byte.

Top module: `pcibr_regs`

## Requirements
- R1: Offsets 0x000 to 0x0FC read and write the 64 words of the configuration header as full 32-bit words.
- R2: After reset, header word 0x004 reads 0x0290_0080. Its low half is the command word with bit 7 (wait-cycle control) set. Its high half is the status word with bit 4 (capability list), bit 7 (fast back-to-back) and bits 10:9 = 01 (medium select timing) set. Every other header word reads zero.
- R3: Offset 0x1C0 is the configuration target address. It keeps and returns all 32 bits and resets to zero.
- R4: Offset 0x1C4 is the memory base. A write keeps only bits 31:24 and bit 0, so it reads back as value AND 0xFF000001. It resets to zero.
- R5: Offset 0x1C8 is the I/O base. A write keeps only bits 31:18 and bit 0, so it reads back as value AND 0xFFFC0001. It resets to zero.
- R6: `io_out_addr` equals I/O base bits 31:18 joined above the 18-bit `io_win_addr`. It follows an I/O base write from the next clock cycle.
- R7: A full write to 0x220 raises `cfg_req` from the next cycle, with `cfg_write`=1, `cfg_addr` equal to the 0x1C0 register and `cfg_wdata` equal to the written data. `rsp_ready` stays low until `cfg_ack` has been seen. It is then high for exactly the cycle after the acknowledge.
- R8: A full read of 0x220 runs the same cycle with `cfg_write`=0 and returns the `cfg_rdata` value present in the acknowledge cycle.
- R9: A read of an unmapped offset (0x100 to 0x1BC, 0x1CC to 0x21C) returns zero, and a write there changes no register.
- R10: An access with byte enables other than 4'b1111, or with a misaligned address, is invalid. A write is ignored, a read returns zero, and no configuration cycle starts, even at 0x220.
- R11: Output line k of `irq_out` is high exactly when some slot with a high `slot_irq` has device number (devfn bits 7:3) modulo 4 equal to k.
- R12: Every access other than a valid data-port access completes in its own cycle: `rsp_ready` is high in the same cycle as `req_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request, held until rsp_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset in the window |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| rsp_ready | output | 1 | Access completes in this cycle |
| rsp_rdata | output | 32 | Read data, valid with rsp_ready |
| cfg_req | output | 1 | Configuration cycle outstanding |
| cfg_write | output | 1 | Configuration cycle is a write |
| cfg_addr | output | 32 | Configuration target address |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration cycle finished |
| cfg_rdata | input | 32 | Configuration read data, valid with cfg_ack |
| io_win_addr | input | 18 | Address inside the I/O window |
| io_out_addr | output | 32 | Translated I/O-space address |
| slot_devfn | input | 32 | Device/function byte of each of 4 slots |
| slot_irq | input | 4 | Interrupt level of each slot |
| irq_out | output | 4 | Routed interrupt lines |

## Verification
Two pairs of functions can fall in the same cycle. The first is an I/O base write alongside a live window translation. The bench drives a window address in the same cycle as the base write and judges `io_out_addr` against the old base before the clock edge and the new base after it. The second is a stalled data-port access alongside interrupt routing. The bench toggles slot levels while a configuration cycle waits for its acknowledge, and checks that the lines follow at once while the bus stays held and the cycle completes with the right data.

// File: rtl/pcibr_regs.sv
module pcibr_regs #(
  parameter int ADDR_W    = 10,
  parameter int NUM_SLOTS = 4,
  parameter int IRQ_LINES = 4,
  parameter int WIN_BITS  = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [3:0]             req_be,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_ready,
  output logic [31:0]            rsp_rdata,
  output logic                   cfg_req,
  output logic                   cfg_write,
  output logic [31:0]            cfg_addr,
  output logic [31:0]            cfg_wdata,
  input  logic                   cfg_ack,
  input  logic [31:0]            cfg_rdata,
  input  logic [WIN_BITS-1:0]    io_win_addr,
  output logic [31:0]            io_out_addr,
  input  logic [NUM_SLOTS*8-1:0] slot_devfn,
  input  logic [NUM_SLOTS-1:0]   slot_irq,
  output logic [IRQ_LINES-1:0]   irq_out
);
  localparam int HDR_WORDS = 64;
  localparam int LW = $clog2(IRQ_LINES);
  localparam logic [ADDR_W-1:0] OFF_TGT  = ADDR_W'('h1C0);
  localparam logic [ADDR_W-1:0] OFF_MEM  = ADDR_W'('h1C4);
  localparam logic [ADDR_W-1:0] OFF_IO   = ADDR_W'('h1C8);
  localparam logic [ADDR_W-1:0] OFF_PORT = ADDR_W'('h220);
  localparam logic [31:0] MEM_KEEP = 32'hFF00_0001;
  localparam logic [31:0] IO_KEEP  = ~((32'd1 << WIN_BITS) - 32'd1) | 32'd1;
  localparam logic [31:0] HDR_W1_RST = 32'h0290_0080;

  typedef enum logic [1:0] {ST_IDLE, ST_PEND, ST_DONE} st_t;

  st_t         st;
  logic [31:0] hdr [HDR_WORDS];
  logic [31:0] tgt_q, mem_q, io_q, port_q, wdata_q;
  logic        wr_q;

  wire full    = (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
  wire hit_hdr = (req_addr[ADDR_W-1:8] == '0);
  wire is_port = full && (req_addr == OFF_PORT);
  wire idle    = (st == ST_IDLE);
  wire acc     = req_valid && idle && full;
  wire do_wr   = acc && req_write && !is_port;
  wire [5:0] widx = req_addr[7:2];

  assign rsp_ready = (st == ST_DONE) || (req_valid && idle && !is_port);

  always_comb begin
    rsp_rdata = '0;
    if (st == ST_DONE) rsp_rdata = port_q;
    else if (full) begin
      if (hit_hdr)                rsp_rdata = hdr[widx];
      else if (req_addr == OFF_TGT) rsp_rdata = tgt_q;
      else if (req_addr == OFF_MEM) rsp_rdata = mem_q;
      else if (req_addr == OFF_IO)  rsp_rdata = io_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HDR_WORDS; i++) hdr[i] <= (i == 1) ? HDR_W1_RST : 32'h0;
      tgt_q <= '0;
      mem_q <= '0;
      io_q  <= '0;
    end else if (do_wr) begin
      if (hit_hdr)                  hdr[widx] <= req_wdata;
      else if (req_addr == OFF_TGT) tgt_q <= req_wdata;
      else if (req_addr == OFF_MEM) mem_q <= req_wdata & MEM_KEEP;
      else if (req_addr == OFF_IO)  io_q  <= req_wdata & IO_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      port_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid && is_port) begin
          st      <= ST_PEND;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
        end
        ST_PEND: if (cfg_ack) begin
          st     <= ST_DONE;
          port_q <= wr_q ? 32'h0 : cfg_rdata;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req   = (st == ST_PEND);
  assign cfg_write = wr_q;
  assign cfg_addr  = tgt_q;
  assign cfg_wdata = wdata_q;

  assign io_out_addr = {io_q[31:WIN_BITS], io_win_addr};

  always_comb begin
    irq_out = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slot_irq[s]) irq_out[slot_devfn[s*8+3 +: LW]] = 1'b1;
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && !cfg_ack |=> cfg_req && $stable(cfg_addr) && $stable(cfg_write) && $stable(cfg_wdata)); // R7
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !rsp_ready); // R7
  AST_ACK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req && cfg_ack |=> rsp_ready && !cfg_req); // R8
  AST_MEM_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && rsp_ready && idle && req_addr == OFF_MEM |-> (rsp_rdata & ~MEM_KEEP) == 0); // R4
  AST_IO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && rsp_ready && idle && req_addr == OFF_IO |-> (rsp_rdata & ~IO_KEEP) == 0); // R5
  AST_BAD_BE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write && idle && req_be != 4'hF |-> rsp_ready && rsp_rdata == 0); // R10
  AST_NO_CFG_BAD_BE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && idle && req_be != 4'hF |=> !cfg_req); // R10
endmodule

// File: tb/pcibr_regs_tb.sv
module pcibr_regs_tb;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [9:0]  req_addr = 0;
  logic [3:0]  req_be = 0;
  logic [31:0] req_wdata = 0;
  logic        rsp_ready;
  logic [31:0] rsp_rdata;
  logic        cfg_req, cfg_write;
  logic [31:0] cfg_addr, cfg_wdata;
  logic        cfg_ack = 0;
  logic [31:0] cfg_rdata = 0;
  logic [17:0] io_win_addr = 0;
  logic [31:0] io_out_addr;
  logic [31:0] slot_devfn = 0;
  logic [3:0]  slot_irq = 0;
  logic [3:0]  irq_out;

  pcibr_regs u_dut (.*);

  int total = 0, bad = 0;
  int ack_delay = 2, ack_cnt = 0, n_req = 0, n_wr = 0;
  logic prev_req = 0;
  logic [31:0] log_addr = 0, log_data = 0;
  localparam logic [31:0] SCRAMBLE = 32'h5A5A_0F0F;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cfg_req && !prev_req) n_req++;
    prev_req = cfg_req;
    if (cfg_ack) begin
      cfg_ack = 0;
      ack_cnt = 0;
    end else if (cfg_req) begin
      if (ack_cnt == ack_delay) begin
        cfg_ack   = 1;
        cfg_rdata = cfg_addr ^ SCRAMBLE;
        if (cfg_write) begin
          n_wr++;
          log_addr = cfg_addr;
          log_data = cfg_wdata;
        end
      end else ack_cnt++;
    end
  end

  task automatic bus(input logic w, input logic [3:0] be, input logic [9:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output int waits);
    waits = 0;
    @(negedge clk);
    req_valid = 1; req_write = w; req_be = be; req_addr = a; req_wdata = d;
    forever begin
      #1;
      if (rsp_ready) break;
      @(negedge clk);
      waits++;
    end
    rd = rsp_rdata;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  localparam int NV = 22;
  localparam logic [78:0] VEC [NV] = '{
    {1'b0, 4'hF, 10'h004, 32'h0, 32'h0290_0080},
    {1'b0, 4'hF, 10'h000, 32'h0, 32'h0},
    {1'b1, 4'hF, 10'h010, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 4'hF, 10'h010, 32'h0, 32'hDEAD_BEEF},
    {1'b1, 4'hF, 10'h0FC, 32'h1357_9BDF, 32'h0},
    {1'b0, 4'hF, 10'h0FC, 32'h0, 32'h1357_9BDF},
    {1'b0, 4'hF, 10'h1C0, 32'h0, 32'h0},
    {1'b1, 4'hF, 10'h1C0, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'hF, 10'h1C0, 32'h0, 32'hFFFF_FFFF},
    {1'b0, 4'hF, 10'h1C4, 32'h0, 32'h0},
    {1'b1, 4'hF, 10'h1C4, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'hF, 10'h1C4, 32'h0, 32'hFF00_0001},
    {1'b0, 4'hF, 10'h1C8, 32'h0, 32'h0},
    {1'b1, 4'hF, 10'h1C8, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'hF, 10'h1C8, 32'h0, 32'hFFFC_0001},
    {1'b1, 4'hF, 10'h100, 32'h0000_1111, 32'h0},
    {1'b0, 4'hF, 10'h100, 32'h0, 32'h0},
    {1'b1, 4'hF, 10'h1CC, 32'h0, 32'h0},
    {1'b0, 4'hF, 10'h1C0, 32'h0, 32'hFFFF_FFFF},
    {1'b1, 4'h3, 10'h010, 32'h0, 32'h0},
    {1'b0, 4'hF, 10'h010, 32'h0, 32'hDEAD_BEEF},
    {1'b0, 4'h7, 10'h010, 32'h0, 32'h0}
  };
  localparam string VTAG [NV] = '{"R2", "R2", "R1", "R1", "R1", "R1", "R3", "R3", "R3",
    "R4", "R4", "R4", "R5", "R5", "R5", "R9", "R9", "R9", "R9", "R10", "R10", "R10"};

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog R7 actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int wt, req0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    check("R6 reset io", io_out_addr, 32'h0);
    check("R7 reset cfg_req", {31'h0, cfg_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][78], VEC[i][77:74], VEC[i][73:64], VEC[i][63:32], rd, wt);
      if (!VEC[i][78]) check(VTAG[i], rd, VEC[i][31:0]);
      check("R12 single cycle", wt, 0);
    end

    // R6: I/O base write while window translation is live
    io_win_addr = 18'h2ABCD;
    bus(1'b1, 4'hF, 10'h1C8, 32'h1234_5678, rd, wt);
    #1 check("R6 new base", io_out_addr, 32'h1234_0000 | 32'h2ABCD);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_be = 4'hF; req_addr = 10'h1C8; req_wdata = 32'hA000_0000;
    io_win_addr = 18'h00123;
    #1 check("R6 old base before edge", io_out_addr, 32'h1234_0000 | 32'h00123);
    @(posedge clk); #1 req_valid = 0;
    check("R6 after edge", io_out_addr, 32'hA000_0000 | 32'h00123);

    // R7 data port write
    bus(1'b1, 4'hF, 10'h1C0, 32'h8000_0810, rd, wt);
    ack_delay = 3;
    req0 = n_req;
    bus(1'b1, 4'hF, 10'h220, 32'hCAFE_0001, rd, wt);
    check("R7 wait cycles", wt, 5);
    check("R7 cfg addr", log_addr, 32'h8000_0810);
    check("R7 cfg data", log_data, 32'hCAFE_0001);
    check("R7 one request", n_req - req0, 1);
    check("R7 write seen", n_wr, 1);

    // R8 data port read with interrupts changing meanwhile (R11)
    slot_devfn = {8'h20, 8'h0A, 8'h18, 8'h08};
    ack_delay = 4;
    fork
      bus(1'b0, 4'hF, 10'h220, 32'h0, rd, wt);
      begin
        @(negedge clk); @(negedge clk);
        slot_irq = 4'b0001; #1;
        check("R11 slot0 dev1", irq_out, 4'b0010);
        check("R7 held", {31'h0, rsp_ready}, 32'h0);
        @(negedge clk);
        slot_irq = 4'b1010; #1;
        check("R11 dev3 and dev4", irq_out, 4'b1001);
        @(negedge clk);
        slot_irq = 4'b0101; #1;
        check("R11 shared line", irq_out, 4'b0010);
      end
    join
    check("R8 read data", rd, 32'h8000_0810 ^ SCRAMBLE);
    check("R8 wait cycles", wt, 6);
    check("R8 no write", n_wr, 1);
    slot_irq = 4'b0000; #1;
    check("R11 all low", irq_out, 4'b0000);

    // R10 invalid data port access
    req0 = n_req;
    bus(1'b0, 4'h1, 10'h220, 32'h0, rd, wt);
    check("R10 port read zero", rd, 32'h0);
    check("R10 port no wait", wt, 0);
    bus(1'b1, 4'hE, 10'h220, 32'h1, rd, wt);
    repeat (3) @(negedge clk);
    check("R10 no cfg cycle", n_req - req0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule